// File: doc/BRIEF.md
# Character and Bitmap Pixel Compositor

This block produces the 24-bit colour of every pixel of a 640x480 picture from two independently stored layers. A timing generator supplies the current row and column each clock. The character layer divides the screen into 8x8 cells; each cell has one 8-bit code in a cell map, and that code selects an 8x8 one-bit pattern from a fixed glyph table. The bitmap layer stores one bit per pixel, packed into 32-bit words laid out linearly across the screen. A layer mode, a frame (border) enable and three colours are held in a small register set.

A host loads the registers, the cell map and the bitmap through one write port. The port carries a target select, a word address and 32 bits of data. Lookups take a fixed two-clock latency, and the position is carried through the same stages, so the result always belongs to the row and column given two edges earlier.

The layer mode works as a four-state selector. BLANK shows background only. TEXT shows the character layer. BITMAP shows the bitmap layer. MIX combines both. The host moves between any two modes by writing the control register. There are no other transitions.

Top module: `text_bitmap_mixer`

## Requirements
- R1: While reset is low, and after reset until the registers are written, `pixel_o` is 0 (all registers clear to 0, mode BLANK, frame off).
- R2: The pixel for the row/column sampled at rising edge k appears on `pixel_o` right after edge k+1, with a new position accepted every clock.
- R3: Any position with row >= 480 or column >= 640 yields `pixel_o` = 0, whatever the mode and frame settings.
- R4: The character bit at (r,c) uses cell index (r/8)*80 + c/8. The cell map holds code q for that cell. The glyph row pattern is q XOR (1 << (r mod 8)), 8 bits wide. The pixel bit is bit 7-(c mod 8) of that pattern, so bit 7 is the leftmost pixel.
- R5: The bitmap bit at (r,c) is bit 31-(c mod 32) of word (r*640+c)/32, so words run along a line and continue on the next line.
- R6: Control bits [1:0] select the mode. 0 = BLANK: every active pixel is off. 1 = TEXT: the character bit is used. 2 = BITMAP: the bitmap bit is used. 3 = MIX: the pixel is on when either bit is set.
- R7: An active pixel that is on shows the foreground colour. A pixel that is off shows the background colour.
- R8: Control bit 2 enables the frame. Active pixels in row 0, row 479, column 0 or column 639 then show the frame colour, and this overrides both layers. With bit 2 clear, those pixels show layer content.
- R9: Write port. `wr_sel_i` = 0 writes a register chosen by address: 0 is control, 1 is foreground, 2 is background and 3 is frame colour. Colours use data[23:0], with R in [23:16], G in [15:8] and B in [7:0]. `wr_sel_i` = 1 writes data[7:0] into the cell map at the given cell index. `wr_sel_i` = 2 writes a 32-bit bitmap word. `wr_sel_i` = 3 writes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| row_i | input | 10 | Current row from the timing generator |
| col_i | input | 10 | Current column from the timing generator |
| wr_en_i | input | 1 | Host write strobe |
| wr_sel_i | input | 2 | Write target: registers, cell map, bitmap, none |
| wr_addr_i | input | 14 | Register number, cell index or bitmap word index |
| wr_data_i | input | 32 | Write data |
| pixel_o | output | 24 | RGB pixel, R in the top byte |

## Verification
The bench probes the four screen edges with the frame enabled and disabled. A design that tested the wrong limit, such as 480 instead of 479, would leave a row or column unframed. Positions just past the active area are checked for black. A design that wrapped the cell or word index there would show leftover content. A full 8x8 cell and whole 32-pixel words are scanned, which catches a reversed bit order as a mirrored image. Back-to-back alternating probes catch a position path delayed by a different number of stages from the lookups, which would shift colours by one pixel.

// File: rtl/disp_pkg.sv
package disp_pkg;
    localparam int H_ACT     = 640;
    localparam int V_ACT     = 480;
    localparam int CELL_LG   = 3;
    localparam int WORD_LG   = 5;
    localparam int COORD_W   = 10;
    localparam int RGB_W     = 24;
    localparam int CODE_W    = 8;
    localparam int DATA_W    = 32;
    localparam int PIPE_LAT  = 2;

    localparam int CELL      = 1 << CELL_LG;
    localparam int WORD_W    = 1 << WORD_LG;
    localparam int TILE_COLS = H_ACT / CELL;
    localparam int TILE_ROWS = V_ACT / CELL;
    localparam int TILES     = TILE_COLS * TILE_ROWS;
    localparam int BM_WORDS  = (H_ACT * V_ACT) / WORD_W;
    localparam int TILE_AW   = $clog2(TILES);
    localparam int BM_AW     = $clog2(BM_WORDS);
    localparam int WR_AW     = (TILE_AW > BM_AW) ? TILE_AW : BM_AW;
    localparam int PIX_AW    = $clog2(H_ACT * V_ACT);

    typedef enum logic [1:0] {
        MODE_BLANK  = 2'd0,
        MODE_TEXT   = 2'd1,
        MODE_BITMAP = 2'd2,
        MODE_MIX    = 2'd3
    } layer_mode_t;

    typedef enum logic [1:0] {
        SEL_REG  = 2'd0,
        SEL_TILE = 2'd1,
        SEL_BMP  = 2'd2,
        SEL_NONE = 2'd3
    } wr_target_t;

    typedef struct packed {
        logic              frame_en;
        layer_mode_t       mode;
        logic [RGB_W-1:0]  fg;
        logic [RGB_W-1:0]  bg;
        logic [RGB_W-1:0]  frame;
    } disp_cfg_t;
endpackage

// File: rtl/disp_regs.sv
module disp_regs
    import disp_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en_i,
    input  logic [1:0]       wr_addr_i,
    input  logic [RGB_W-1:0] wr_data_i,
    output disp_cfg_t        cfg_o
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_o <= '0;
        end else if (wr_en_i) begin
            unique case (wr_addr_i)
                2'd0: begin
                    cfg_o.mode     <= layer_mode_t'(wr_data_i[1:0]);
                    cfg_o.frame_en <= wr_data_i[2];
                end
                2'd1: cfg_o.fg    <= wr_data_i;
                2'd2: cfg_o.bg    <= wr_data_i;
                2'd3: cfg_o.frame <= wr_data_i;
            endcase
        end
    end

    // R9: a control write lands in the mode field on the next cycle
    property p_ctrl_write_r9;
        @(posedge clk) disable iff (!rst_n)
        (wr_en_i && wr_addr_i == 2'd0) |=> (cfg_o.mode == $past(wr_data_i[1:0]));
    endproperty
    a_ctrl_write_r9: assert property (p_ctrl_write_r9);
endmodule

// File: rtl/char_layer.sv
module char_layer
    import disp_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en_i,
    input  logic [TILE_AW-1:0] wr_addr_i,
    input  logic [CODE_W-1:0]  wr_code_i,
    input  logic [COORD_W-1:0] row_i,
    input  logic [COORD_W-1:0] col_i,
    input  logic               act_i,
    input  logic [CELL_LG-1:0] row_lo_s1_i,
    input  logic [CELL_LG-1:0] col_lo_s1_i,
    output logic               bit_o
);
    logic [CODE_W-1:0]  tile_map [TILES];
    logic [CODE_W-1:0]  code_q;
    logic [PIX_AW-1:0]  cell_lin;
    logic [TILE_AW-1:0] rd_addr;
    logic [CELL-1:0]    glyph_row;

    function automatic logic [CELL-1:0] glyph_lookup(input logic [CODE_W-1:0] code,
                                                     input logic [CELL_LG-1:0] r);
        return CELL'(code) ^ (CELL'(1) << r);
    endfunction

    always_comb begin
        cell_lin = PIX_AW'(row_i >> CELL_LG) * PIX_AW'(TILE_COLS) + PIX_AW'(col_i >> CELL_LG);
        rd_addr  = act_i ? TILE_AW'(cell_lin) : '0;
    end

    always_ff @(posedge clk) begin
        if (wr_en_i) tile_map[wr_addr_i] <= wr_code_i;
        code_q <= tile_map[rd_addr];
    end

    always_comb begin
        glyph_row = glyph_lookup(code_q, row_lo_s1_i);
        bit_o     = glyph_row[~col_lo_s1_i];
    end

    // R4: an active position always maps inside the cell map
    property p_cell_in_range_r4;
        @(posedge clk) disable iff (!rst_n)
        act_i |-> (cell_lin < PIX_AW'(TILES));
    endproperty
    a_cell_in_range_r4: assert property (p_cell_in_range_r4);
endmodule

// File: rtl/bitmap_layer.sv
module bitmap_layer
    import disp_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en_i,
    input  logic [BM_AW-1:0]   wr_addr_i,
    input  logic [WORD_W-1:0]  wr_data_i,
    input  logic [COORD_W-1:0] row_i,
    input  logic [COORD_W-1:0] col_i,
    input  logic               act_i,
    input  logic [WORD_LG-1:0] col_lo_s1_i,
    output logic               bit_o
);
    logic [WORD_W-1:0] bitmap [BM_WORDS];
    logic [WORD_W-1:0] word_q;
    logic [PIX_AW-1:0] pix_lin;
    logic [BM_AW-1:0]  rd_addr;

    always_comb begin
        pix_lin = PIX_AW'(row_i) * PIX_AW'(H_ACT) + PIX_AW'(col_i);
        rd_addr = act_i ? BM_AW'(pix_lin >> WORD_LG) : '0;
    end

    always_ff @(posedge clk) begin
        if (wr_en_i) bitmap[wr_addr_i] <= wr_data_i;
        word_q <= bitmap[rd_addr];
    end

    assign bit_o = word_q[~col_lo_s1_i];

    // R5: an active position always lands on a stored word
    property p_word_in_range_r5;
        @(posedge clk) disable iff (!rst_n)
        act_i |-> ((pix_lin >> WORD_LG) < PIX_AW'(BM_WORDS));
    endproperty
    a_word_in_range_r5: assert property (p_word_in_range_r5);
endmodule

// File: rtl/text_bitmap_mixer.sv
module text_bitmap_mixer
    import disp_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [COORD_W-1:0] row_i,
    input  logic [COORD_W-1:0] col_i,
    input  logic               wr_en_i,
    input  logic [1:0]         wr_sel_i,
    input  logic [WR_AW-1:0]   wr_addr_i,
    input  logic [DATA_W-1:0]  wr_data_i,
    output logic [RGB_W-1:0]   pixel_o
);
    wr_target_t         wr_tgt;
    disp_cfg_t          cfg;
    logic               act_in;
    logic [COORD_W-1:0] row_s1, col_s1;
    logic               act_s1;
    logic               txt_bit, bmp_bit, lit, edge_s1;
    logic [RGB_W-1:0]   pix_nxt;

    assign wr_tgt = wr_target_t'(wr_sel_i);
    assign act_in = (row_i < COORD_W'(V_ACT)) && (col_i < COORD_W'(H_ACT));

    disp_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en_i && wr_tgt == SEL_REG),
        .wr_addr_i (wr_addr_i[1:0]),
        .wr_data_i (wr_data_i[RGB_W-1:0]),
        .cfg_o     (cfg)
    );

    char_layer u_char (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en_i     (wr_en_i && wr_tgt == SEL_TILE),
        .wr_addr_i   (wr_addr_i[TILE_AW-1:0]),
        .wr_code_i   (wr_data_i[CODE_W-1:0]),
        .row_i       (row_i),
        .col_i       (col_i),
        .act_i       (act_in),
        .row_lo_s1_i (row_s1[CELL_LG-1:0]),
        .col_lo_s1_i (col_s1[CELL_LG-1:0]),
        .bit_o       (txt_bit)
    );

    bitmap_layer u_bitmap (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en_i     (wr_en_i && wr_tgt == SEL_BMP),
        .wr_addr_i   (wr_addr_i[BM_AW-1:0]),
        .wr_data_i   (wr_data_i[WORD_W-1:0]),
        .row_i       (row_i),
        .col_i       (col_i),
        .act_i       (act_in),
        .col_lo_s1_i (col_s1[WORD_LG-1:0]),
        .bit_o       (bmp_bit)
    );

    // stage 1: position travels alongside the memory reads
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            row_s1 <= '0;
            col_s1 <= '0;
            act_s1 <= 1'b0;
        end else begin
            row_s1 <= row_i;
            col_s1 <= col_i;
            act_s1 <= act_in;
        end
    end

    // stage 2: layer selection and colour choice
    always_comb begin
        unique case (cfg.mode)
            MODE_BLANK:  lit = 1'b0;
            MODE_TEXT:   lit = txt_bit;
            MODE_BITMAP: lit = bmp_bit;
            MODE_MIX:    lit = txt_bit | bmp_bit;
        endcase
        edge_s1 = (row_s1 == '0) || (row_s1 == COORD_W'(V_ACT - 1)) ||
                  (col_s1 == '0) || (col_s1 == COORD_W'(H_ACT - 1));
        if (!act_s1)                       pix_nxt = '0;
        else if (cfg.frame_en && edge_s1)  pix_nxt = cfg.frame;
        else if (lit)                      pix_nxt = cfg.fg;
        else                               pix_nxt = cfg.bg;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pixel_o <= '0;
        else        pixel_o <= pix_nxt;
    end

    // R3: positions outside the picture come out black
    property p_black_outside_r3;
        @(posedge clk) disable iff (!rst_n)
        !act_s1 |=> (pixel_o == '0);
    endproperty
    a_black_outside_r3: assert property (p_black_outside_r3);

    // R8: frame colour wins on the outer ring
    property p_frame_wins_r8;
        @(posedge clk) disable iff (!rst_n)
        (act_s1 && edge_s1 && cfg.frame_en) |=> (pixel_o == $past(cfg.frame));
    endproperty
    a_frame_wins_r8: assert property (p_frame_wins_r8);

    // R6: BLANK mode shows background away from the frame
    property p_blank_bg_r6;
        @(posedge clk) disable iff (!rst_n)
        (act_s1 && !(cfg.frame_en && edge_s1) && cfg.mode == MODE_BLANK)
            |=> (pixel_o == $past(cfg.bg));
    endproperty
    a_blank_bg_r6: assert property (p_blank_bg_r6);
endmodule

// File: tb/text_bitmap_mixer_bench.sv
module text_bitmap_mixer_bench;
    import disp_pkg::*;

    localparam time CLK_PERIOD = 10;
    localparam int  LAT        = PIPE_LAT;

    logic               clk = 1'b0;
    logic               rst_n;
    logic [COORD_W-1:0] row_i, col_i;
    logic               wr_en_i;
    logic [1:0]         wr_sel_i;
    logic [WR_AW-1:0]   wr_addr_i;
    logic [DATA_W-1:0]  wr_data_i;
    logic [RGB_W-1:0]   pixel_o;

    text_bitmap_mixer u_text_bitmap_mixer (
        .clk(clk), .rst_n(rst_n), .row_i(row_i), .col_i(col_i),
        .wr_en_i(wr_en_i), .wr_sel_i(wr_sel_i), .wr_addr_i(wr_addr_i),
        .wr_data_i(wr_data_i), .pixel_o(pixel_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    typedef struct {
        int               issue;
        logic [RGB_W-1:0] exp;
        string            tag;
        int               r;
        int               c;
    } item_t;
    item_t sbq[$];

    int checks = 0;
    int errors = 0;

    // shadow state, filled only from what the bench writes
    logic [7:0]  tmap_s[int];
    logic [31:0] bmap_s[int];
    int          mode_s = 0;
    bit          frame_s = 1'b0;
    logic [23:0] fg_s = '0, bg_s = '0, fc_s = '0;

    function automatic logic [23:0] expect_pix(int r, int c);
        int ti, wi;
        logic [7:0] code, grow;
        logic [31:0] w;
        bit tb, bb, on;
        if (r >= 480 || c >= 640) return 24'h0;
        if (frame_s && (r == 0 || r == 479 || c == 0 || c == 639)) return fc_s;
        ti   = (r / 8) * 80 + c / 8;
        code = tmap_s.exists(ti) ? tmap_s[ti] : 8'h00;
        grow = code ^ (8'h01 << (r % 8));
        tb   = grow[7 - (c % 8)];
        wi   = (r * 640 + c) / 32;
        w    = bmap_s.exists(wi) ? bmap_s[wi] : 32'h0;
        bb   = w[31 - (c % 32)];
        case (mode_s)
            0: on = 1'b0;
            1: on = tb;
            2: on = bb;
            default: on = tb | bb;
        endcase
        return on ? fg_s : bg_s;
    endfunction

    task automatic host_write(input int sel, input int addr, input logic [31:0] data);
        @(negedge clk);
        wr_en_i   = 1'b1;
        wr_sel_i  = 2'(sel);
        wr_addr_i = WR_AW'(addr);
        wr_data_i = data;
        case (sel)
            0: case (addr)
                   0: begin mode_s = int'(data[1:0]); frame_s = data[2]; end
                   1: fg_s = data[23:0];
                   2: bg_s = data[23:0];
                   default: fc_s = data[23:0];
               endcase
            1: tmap_s[addr] = data[7:0];
            2: bmap_s[addr] = data;
            default: ;
        endcase
        @(posedge clk);
        #1 wr_en_i = 1'b0;
    endtask

    task automatic drain();
        repeat (LAT + 2) @(negedge clk);
    endtask

    task automatic probe(input int r, input int c, input string tag);
        item_t it;
        @(negedge clk);
        row_i = COORD_W'(r);
        col_i = COORD_W'(c);
        it.issue = cyc;
        it.exp   = expect_pix(r, c);
        it.tag   = tag;
        it.r     = r;
        it.c     = c;
        sbq.push_back(it);
    endtask

    // monitor: pops each expected pixel in the cycle it is due
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (sbq.size() > 0 && sbq[0].issue + LAT == cyc) begin
                item_t it;
                it = sbq.pop_front();
                checks++;
                if (pixel_o !== it.exp) begin
                    errors++;
                    $display("FAIL %s at row %0d col %0d: actual %06h expected %06h",
                             it.tag, it.r, it.c, pixel_o, it.exp);
                end
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0; row_i = '0; col_i = '0;
        wr_en_i = 1'b0; wr_sel_i = '0; wr_addr_i = '0; wr_data_i = '0;
        repeat (4) @(negedge clk);
        checks++;
        if (pixel_o !== 24'h0) begin
            errors++;
            $display("FAIL R1 in reset: actual %06h expected 000000", pixel_o);
        end
        rst_n = 1'b1;
        // R1: cleared registers give black everywhere
        probe(10, 10, "R1");
        probe(0, 0, "R1");
        probe(200, 300, "R1");
        drain();

        // R9: registers, cell map, bitmap
        host_write(0, 1, 32'h00FF8000);
        host_write(0, 2, 32'h00102030);
        host_write(0, 3, 32'h0000FF00);
        host_write(0, 0, 32'h1);
        for (int tr = 0; tr < 60; tr++) begin
            if (tr <= 2 || tr == 59)
                for (int tc = 0; tc < 80; tc++)
                    host_write(1, tr * 80 + tc, 32'((tr * 80 + tc) * 37 + 5));
        end
        for (int w = 100; w < 120; w++)  host_write(2, w, (w * 32'h9E3779B1) ^ 32'h5A5A0F0F);
        for (int r = 16; r < 24; r++)
            for (int k = 0; k < 2; k++)
                host_write(2, r * 20 + k, ((r * 20 + k) * 32'h9E3779B1) ^ 32'h5A5A0F0F);
        for (int w = 9580; w < 9600; w++) host_write(2, w, (w * 32'h9E3779B1) ^ 32'h5A5A0F0F);
        host_write(3, 0, 32'hFFFFFFFF); // no target: must not change anything
        drain();

        // R4: full glyph cell and bottom-right cell, text mode
        for (int r = 16; r < 24; r++)
            for (int c = 24; c < 32; c++) probe(r, c, "R4");
        for (int r = 472; r < 480; r++)
            for (int c = 632; c < 640; c++) probe(r, c, "R4");
        for (int c = 0; c < 16; c++) probe(0, c, "R8_off");

        // R2: alternating positions back to back
        for (int k = 0; k < 16; k++) begin
            probe(16 + (k % 8), 24 + k / 2, "R2");
            probe(480, k, "R2");
        end

        // R3: outside the picture
        probe(480, 5, "R3");
        probe(5, 640, "R3");
        probe(1023, 1023, "R3");
        probe(479, 639, "R3_inside");
        drain();

        // R5: bitmap only
        host_write(0, 0, 32'h2);
        drain();
        for (int c = 0; c < 64; c++) probe(5, c, "R5");
        for (int c = 0; c < 32; c++) probe(16, c, "R5");
        for (int c = 600; c < 640; c++) probe(479, c, "R5");
        drain();

        // R6: mixed and blank
        host_write(0, 0, 32'h3);
        drain();
        for (int r = 16; r < 24; r++)
            for (int c = 24; c < 32; c++) probe(r, c, "R6_mix");
        drain();
        host_write(0, 0, 32'h0);
        drain();
        for (int c = 20; c < 40; c++) probe(17, c, "R6_blank");
        drain();

        // R7: new colours, text mode
        host_write(0, 1, 32'h000000FF);
        host_write(0, 2, 32'h00ABCDEF);
        host_write(0, 0, 32'h1);
        drain();
        for (int c = 24; c < 32; c++) probe(16, c, "R7");
        drain();

        // R8: frame enabled over text
        host_write(0, 0, 32'h5);
        drain();
        for (int c = 0; c < 16; c++)    probe(0, c, "R8");
        for (int c = 600; c < 640; c++) probe(479, c, "R8");
        for (int r = 0; r < 24; r++)    probe(r, 0, "R8");
        for (int r = 0; r < 24; r++)    probe(r, 639, "R8");
        for (int c = 1; c < 9; c++)     probe(1, c, "R8_inner");
        probe(480, 0, "R3_frame");
        drain();

        // R9: rewrite a cell and frame colour, then observe
        host_write(1, 0, 32'h000000F0);
        host_write(0, 3, 32'h00123456);
        drain();
        for (int r = 0; r < 8; r++)
            for (int c = 0; c < 8; c++) probe(r, c, "R9");
        drain();

        if (sbq.size() != 0) begin
            errors++;
            $display("FAIL R2 leftover items: actual %0d expected 0", sbq.size());
        end
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule